// File: doc/BRIEF.md
# Memory-Card Host Command Launch Registers

This block is the register front end of a memory-card host controller. Software reaches it over a plain 32-bit word-addressed register bus with a write strobe and a combinational read. It holds four kinds of state:

- a global control word, with three self-clearing reset requests;
- a staged clock control word;
- the bus lane selection, the block size and the byte count;
- the command argument and the command word.

Writing the command word with its start bit set launches an operation. The start bit reads back as 1 until the operation has been accepted.

There are two kinds of command. A clock-update-only command involves no card traffic. It copies the staged clock word into a shadow copy that drives the clock generator, and its start bit drops after a fixed number of cycles. Every other command goes to a downstream command engine as a single-cycle launch pulse, together with the command word and the argument. That command's start bit drops when the engine returns its done strobe.

A command may ask to wait for the previous data transfer to finish. Such a command is held back while the data path reports that it is busy. A soft reset returns the whole register set to its reset values, except the FIFO-access select bit. It also aborts any command in flight.

Top module: `card_host_launch`

## Requirements
- R1: After reset, reads return the following values (word index in brackets): global control [0] = 0, clock control [1] = 0, lane select [2] = 0, block size [3] = 0x200, byte count [4] = 0x200, argument [5] = 0, command [6] = 0. The shadow clock outputs and all strobes are 0.
- R2: Writes to these registers read back as written: clock control (bits [17:0]), block size (low 16 bits), byte count, argument, and command (bits [30:0]). Unmapped bits read as 0.
- R3: In global control, the following bits are ordinary read/write bits: bit 4 (interrupt enable), bit 5 (DMA enable) and bit 31 (CPU access to the FIFO). Each drives its own output. Bits 3 and 6 to 30 read as 0.
- R4: The lane select field (bits [1:0]) accepts 0 (one lane), 1 (four lanes) and 2 (eight lanes). A write of 3 leaves the field unchanged.
- R5: Writing 1 to global control bit 0 starts a soft reset. Bit 0 then reads 1 for RST_CYCLES cycles (8) and clears itself. The write returns every register to its R1 value, except global control bit 31, which keeps its previous value. Register writes made while the soft reset is running are ignored.
- R6: Writing 1 to global control bit 1 requests a FIFO flush, and bit 2 requests a DMA flush. Each bit reads 1, and drives its flush output high, for FLUSH_CYCLES cycles (4), then clears itself.
- R7: A write to clock control does not change the shadow clock outputs (divider, card clock on = bit 16, low power = bit 17).
- R8: A command written with bit 31 (start) and bit 21 (clock update only) keeps bit 31 reading 1 for UPD_CYCLES cycles (4). It raises no launch pulse. The shadow clock outputs take the clock control value in the same cycle that bit 31 clears.
- R9: A command written with bit 31 set and bit 21 clear raises the launch output for exactly one cycle, the cycle after the write. The launch output presents the command word and the argument. Bit 31 stays 1 until the done input is seen.
- R10: A write to the command register while bit 31 reads 1 is ignored. The word, the readback and the engine outputs are all unchanged.
- R11: A command with bit 13 (wait for the previous transfer) set is held, with no launch and no update countdown, while the data-busy input is high. It is released in the first cycle that input is low.
- R12: A command write with bit 31 clear stores the word and does not launch.
- R13: A soft reset aborts a command in flight, and bit 31 of the command register reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ctl_irq_en | output | 1 | Interrupt enable bit |
| ctl_dma_en | output | 1 | DMA enable bit |
| ctl_cpu_fifo | output | 1 | CPU access to FIFO select |
| fifo_flush | output | 1 | FIFO flush in progress |
| dma_flush | output | 1 | DMA flush in progress |
| clkgen_div | output | DIV_W | Shadow clock divider |
| clkgen_on | output | 1 | Shadow card clock enable |
| clkgen_lowpwr | output | 1 | Shadow low-power enable |
| lane_sel | output | 2 | Bus lane selection |
| blk_size | output | BLK_W | Block size |
| byte_count | output | CNT_W | Byte count |
| eng_launch | output | 1 | One-cycle launch to the command engine |
| eng_cmd | output | 32 | Command word, bit 31 = start pending |
| eng_arg | output | 32 | Command argument |
| eng_done | input | 1 | Command engine accepted the command |
| xfer_busy | input | 1 | Previous data transfer still running |

## Verification
The bench checks the boundaries of each self-clearing window: the last cycle in which the soft reset bit, a flush bit or an update start bit still reads 1, and the first cycle in which it reads 0. An off-by-one counter would show up as a window one cycle short or long. It issues a second command while the first is pending; a design that accepted it would overwrite the word and launch twice. It also writes the reserved lane code, which a careless decode would store. It holds the data-busy input across a wait-flagged launch and across a wait-flagged clock update, where a missing gate would release early. It checks that a soft reset clears everything but the FIFO-access bit and kills a pending launch.

// File: rtl/mmc_launch_pkg.sv
package mmc_launch_pkg;
   // register word indices
   localparam int unsigned IX_GCTRL = 0;
   localparam int unsigned IX_CLOCK = 1;
   localparam int unsigned IX_LANES = 2;
   localparam int unsigned IX_BLKSZ = 3;
   localparam int unsigned IX_BYTES = 4;
   localparam int unsigned IX_ARG   = 5;
   localparam int unsigned IX_CMD   = 6;

   // global control fields
   localparam int unsigned GC_IRQ   = 4;
   localparam int unsigned GC_DMAEN = 5;
   localparam int unsigned GC_CPUF  = 31;
   localparam int unsigned GC_NRST  = 3;   // soft, fifo, dma reset bits 0..2

   // clock control fields
   localparam int unsigned CK_ON = 16;
   localparam int unsigned CK_LP = 17;

   // command fields
   localparam int unsigned CM_START = 31;
   localparam int unsigned CM_UPD   = 21;
   localparam int unsigned CM_WAIT  = 13;

   localparam logic [31:0] SIZE_RESET = 32'h0000_0200;

   typedef enum logic [1:0] {
      LANES_1  = 2'd0,
      LANES_4  = 2'd1,
      LANES_8  = 2'd2,
      LANES_NA = 2'd3
   } lanes_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ARM,
      SQ_UPD,
      SQ_RUN
   } seq_state_e;
endpackage

// File: rtl/mmc_busy_timer.sv
module mmc_busy_timer #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic trig,
   output logic busy
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("mmc_busy_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clear)                 cnt_q <= '0;
      else if (trig && cnt_q == '0)   cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq
   import mmc_launch_pkg::*;
#(
   parameter int unsigned UPD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic accept,
   input  logic upd_only,
   input  logic wait_prev,
   input  logic xfer_busy,
   input  logic eng_done,
   output logic busy,
   output logic eng_launch,
   output logic clk_latch
);
   localparam int unsigned CW = $clog2(UPD_CYCLES + 1);

   if (UPD_CYCLES < 2) begin : g_bad_upd
      $error("mmc_cmd_seq: UPD_CYCLES must be at least 2");
   end

   seq_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          release_ok;

   assign release_ok = !(wait_prev && xfer_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
      end else if (abort) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (accept) state_q <= SQ_ARM;
            SQ_ARM: if (release_ok) begin
               if (upd_only) begin
                  state_q <= SQ_UPD;
                  cnt_q   <= CW'(UPD_CYCLES - 1);
               end else begin
                  state_q <= SQ_RUN;
               end
            end
            SQ_UPD: begin
               if (cnt_q <= CW'(1)) state_q <= SQ_IDLE;
               cnt_q <= cnt_q - 1'b1;
            end
            SQ_RUN: if (eng_done) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != SQ_IDLE);
   assign eng_launch = (state_q == SQ_ARM) && release_ok && !upd_only && !abort;
   assign clk_latch  = (state_q == SQ_UPD) && (cnt_q == CW'(1)) && !abort;
endmodule

// File: rtl/card_host_launch.sv
module card_host_launch
   import mmc_launch_pkg::*;
#(
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned DIV_W        = 16,
   parameter int unsigned BLK_W        = 16,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned RST_CYCLES   = 8,
   parameter int unsigned FLUSH_CYCLES = 4,
   parameter int unsigned UPD_CYCLES   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              ctl_irq_en,
   output logic              ctl_dma_en,
   output logic              ctl_cpu_fifo,
   output logic              fifo_flush,
   output logic              dma_flush,
   output logic [DIV_W-1:0]  clkgen_div,
   output logic              clkgen_on,
   output logic              clkgen_lowpwr,
   output logic [1:0]        lane_sel,
   output logic [BLK_W-1:0]  blk_size,
   output logic [CNT_W-1:0]  byte_count,
   output logic              eng_launch,
   output logic [31:0]       eng_cmd,
   output logic [31:0]       eng_arg,
   input  logic              eng_done,
   input  logic              xfer_busy
);
   if (ADDR_W < 3)                 begin : g_bad_addr $error("ADDR_W must be at least 3"); end
   if (DIV_W < 1 || DIV_W > 16)    begin : g_bad_div  $error("DIV_W must be 1..16"); end
   if (BLK_W < 10 || BLK_W > 32)   begin : g_bad_blk  $error("BLK_W must be 10..32"); end
   if (CNT_W < 10 || CNT_W > 32)   begin : g_bad_cnt  $error("CNT_W must be 10..32"); end

   logic               wr_ok, hit_gctrl, hit_clock, hit_lanes, hit_blk, hit_bytes, hit_arg, hit_cmd;
   logic               soft_trig, soft_busy, seq_busy, clk_latch, cmd_accept;
   logic [GC_NRST-1:0] rst_busy;

   logic               gc_irq_q, gc_dma_q, gc_cpu_q;
   logic [DIV_W-1:0]   ck_div_q, sh_div_q;
   logic               ck_on_q, ck_lp_q, sh_on_q, sh_lp_q;
   logic [1:0]         lane_q;
   logic [BLK_W-1:0]   blk_q;
   logic [CNT_W-1:0]   bytes_q;
   logic [31:0]        arg_q;
   logic [30:0]        cmd_q;

   assign soft_busy = rst_busy[0];
   assign wr_ok     = reg_wen && !soft_busy;
   assign hit_gctrl = wr_ok && (reg_addr == ADDR_W'(IX_GCTRL));
   assign hit_clock = wr_ok && (reg_addr == ADDR_W'(IX_CLOCK));
   assign hit_lanes = wr_ok && (reg_addr == ADDR_W'(IX_LANES));
   assign hit_blk   = wr_ok && (reg_addr == ADDR_W'(IX_BLKSZ));
   assign hit_bytes = wr_ok && (reg_addr == ADDR_W'(IX_BYTES));
   assign hit_arg   = wr_ok && (reg_addr == ADDR_W'(IX_ARG));
   assign hit_cmd   = wr_ok && (reg_addr == ADDR_W'(IX_CMD)) && !seq_busy;
   assign soft_trig = hit_gctrl && reg_wdata[0];
   assign cmd_accept = hit_cmd && reg_wdata[CM_START];

   // self-clearing reset request bits: bit 0 soft, bits 1..2 flushes
   for (genvar g = 0; g < GC_NRST; g++) begin : g_rst
      localparam int unsigned HOLD = (g == 0) ? RST_CYCLES : FLUSH_CYCLES;
      mmc_busy_timer #(.CYCLES(HOLD)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .clear ((g == 0) ? 1'b0 : soft_trig),
         .trig  (hit_gctrl && reg_wdata[g]),
         .busy  (rst_busy[g])
      );
   end

   mmc_cmd_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (soft_trig || soft_busy),
      .accept     (cmd_accept),
      .upd_only   (cmd_q[CM_UPD]),
      .wait_prev  (cmd_q[CM_WAIT]),
      .xfer_busy  (xfer_busy),
      .eng_done   (eng_done),
      .busy       (seq_busy),
      .eng_launch (eng_launch),
      .clk_latch  (clk_latch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gc_irq_q <= 1'b0; gc_dma_q <= 1'b0; gc_cpu_q <= 1'b0;
         ck_div_q <= '0;   ck_on_q  <= 1'b0; ck_lp_q  <= 1'b0;
         sh_div_q <= '0;   sh_on_q  <= 1'b0; sh_lp_q  <= 1'b0;
         lane_q   <= LANES_1;
         blk_q    <= BLK_W'(SIZE_RESET);
         bytes_q  <= CNT_W'(SIZE_RESET);
         arg_q    <= '0;
         cmd_q    <= '0;
      end else if (soft_trig) begin
         gc_irq_q <= 1'b0; gc_dma_q <= 1'b0;
         ck_div_q <= '0;   ck_on_q  <= 1'b0; ck_lp_q  <= 1'b0;
         sh_div_q <= '0;   sh_on_q  <= 1'b0; sh_lp_q  <= 1'b0;
         lane_q   <= LANES_1;
         blk_q    <= BLK_W'(SIZE_RESET);
         bytes_q  <= CNT_W'(SIZE_RESET);
         arg_q    <= '0;
         cmd_q    <= '0;
      end else begin
         if (hit_gctrl) begin
            gc_irq_q <= reg_wdata[GC_IRQ];
            gc_dma_q <= reg_wdata[GC_DMAEN];
            gc_cpu_q <= reg_wdata[GC_CPUF];
         end
         if (hit_clock) begin
            ck_div_q <= reg_wdata[DIV_W-1:0];
            ck_on_q  <= reg_wdata[CK_ON];
            ck_lp_q  <= reg_wdata[CK_LP];
         end
         if (clk_latch) begin
            sh_div_q <= ck_div_q;
            sh_on_q  <= ck_on_q;
            sh_lp_q  <= ck_lp_q;
         end
         if (hit_lanes && reg_wdata[1:0] != LANES_NA) lane_q <= reg_wdata[1:0];
         if (hit_blk)   blk_q   <= reg_wdata[BLK_W-1:0];
         if (hit_bytes) bytes_q <= reg_wdata[CNT_W-1:0];
         if (hit_arg)   arg_q   <= reg_wdata;
         if (hit_cmd)   cmd_q   <= reg_wdata[30:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_W'(IX_GCTRL): reg_rdata = {gc_cpu_q, 25'b0, gc_dma_q, gc_irq_q, 1'b0, rst_busy};
         ADDR_W'(IX_CLOCK): reg_rdata = {14'b0, ck_lp_q, ck_on_q, 16'(ck_div_q)};
         ADDR_W'(IX_LANES): reg_rdata = {30'b0, lane_q};
         ADDR_W'(IX_BLKSZ): reg_rdata = 32'(blk_q);
         ADDR_W'(IX_BYTES): reg_rdata = 32'(bytes_q);
         ADDR_W'(IX_ARG):   reg_rdata = arg_q;
         ADDR_W'(IX_CMD):   reg_rdata = {seq_busy, cmd_q};
         default:           reg_rdata = '0;
      endcase
   end

   assign ctl_irq_en    = gc_irq_q;
   assign ctl_dma_en    = gc_dma_q;
   assign ctl_cpu_fifo  = gc_cpu_q;
   assign fifo_flush    = rst_busy[1];
   assign dma_flush     = rst_busy[2];
   assign clkgen_div    = sh_div_q;
   assign clkgen_on     = sh_on_q;
   assign clkgen_lowpwr = sh_lp_q;
   assign lane_sel      = lane_q;
   assign blk_size      = blk_q;
   assign byte_count    = bytes_q;
   assign eng_cmd       = {seq_busy, cmd_q};
   assign eng_arg       = arg_q;
endmodule

// File: rtl/mmc_launch_chk.sv
module mmc_launch_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eng_launch,
   input logic [31:0]      eng_cmd,
   input logic             xfer_busy,
   input logic             start_busy,
   input logic             clk_latch,
   input logic             soft_trig,
   input logic             soft_busy,
   input logic [DIV_W+1:0] shadow,
   input logic [1:0]       lane_sel
);
   p_launch_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_launch |=> !eng_launch);

   p_cmd_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_busy && $past(start_busy)) |-> $stable(eng_cmd));

   p_wait_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_launch |-> !(eng_cmd[13] && xfer_busy));

   p_upd_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_launch |-> !eng_cmd[21]);

   p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_latch && !soft_trig) |=> $stable(shadow));

   p_soft_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_busy) |=> soft_busy);

   p_lane_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_sel != 2'b11);
endmodule

bind card_host_launch mmc_launch_chk #(.DIV_W(DIV_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eng_launch (eng_launch),
   .eng_cmd    (eng_cmd),
   .xfer_busy  (xfer_busy),
   .start_busy (seq_busy),
   .clk_latch  (clk_latch),
   .soft_trig  (soft_trig),
   .soft_busy  (soft_busy),
   .shadow     ({sh_lp_q, sh_on_q, sh_div_q}),
   .lane_sel   (lane_sel)
);

// File: tb/card_host_launch_test.sv
module card_host_launch_test;
   localparam logic [3:0] A_GC = 4'd0, A_CK = 4'd1, A_LN = 4'd2, A_BS = 4'd3,
                          A_BC = 4'd4, A_AR = 4'd5, A_CM = 4'd6;

   logic        clk = 1'b0;
   logic        rst_n, reg_wen, eng_done, xfer_busy;
   logic [3:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata, eng_cmd, eng_arg;
   logic        ctl_irq_en, ctl_dma_en, ctl_cpu_fifo, fifo_flush, dma_flush;
   logic [15:0] clkgen_div, blk_size;
   logic        clkgen_on, clkgen_lowpwr, eng_launch;
   logic [1:0]  lane_sel;
   logic [31:0] byte_count;

   int n_chk = 0, n_bad = 0, n_launch = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   card_host_launch uut (
      .clk, .rst_n, .reg_wen, .reg_addr, .reg_wdata, .reg_rdata,
      .ctl_irq_en, .ctl_dma_en, .ctl_cpu_fifo, .fifo_flush, .dma_flush,
      .clkgen_div, .clkgen_on, .clkgen_lowpwr, .lane_sel, .blk_size,
      .byte_count, .eng_launch, .eng_cmd, .eng_arg, .eng_done, .xfer_busy
   );

   always begin
      @(posedge clk); #5;
      if (eng_launch) n_launch++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_done();
      eng_done = 1'b1; step(1); eng_done = 1'b0;
   endtask

   function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [31:0] d);
      case (a)
         A_CK:    return d & 32'h0003_FFFF;
         A_BS:    return d & 32'h0000_FFFF;
         default: return d;
      endcase
   endfunction

   function automatic logic [1:0] exp_lane(input logic [1:0] prev, input logic [31:0] d);
      return (d[1:0] == 2'b11) ? prev : d[1:0];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R1: watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int lc;
      logic [1:0] m_lane;
      logic [15:0] m_sh;
      void'($urandom(32'd4711));
      rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
      eng_done = 1'b0; xfer_busy = 1'b0;
      step(3); rst_n = 1'b1; step(1);

      // R1 reset state
      rd(A_GC, v); check("R1 gctrl", v, 32'h0);
      rd(A_CK, v); check("R1 clock", v, 32'h0);
      rd(A_LN, v); check("R1 lanes", v, 32'h0);
      rd(A_BS, v); check("R1 blksz", v, 32'h200);
      rd(A_BC, v); check("R1 bytes", v, 32'h200);
      rd(A_AR, v); check("R1 arg", v, 32'h0);
      rd(A_CM, v); check("R1 cmd", v, 32'h0);
      check("R1 shadow", {clkgen_lowpwr, clkgen_on, clkgen_div}, 32'h0);
      check("R1 launch", eng_launch, 1'b0);

      // R3 global control bits
      wr(A_GC, 32'h8000_0138);
      rd(A_GC, v); check("R3 gctrl read", v, 32'h8000_0030);
      check("R3 outputs", {ctl_cpu_fifo, ctl_dma_en, ctl_irq_en}, 3'b111);

      // R2 / R7 staged clock word
      wr(A_CK, 32'hFFF3_0042);
      rd(A_CK, v); check("R2 clock read", v, 32'h0003_0042);
      check("R7 shadow after write", {clkgen_lowpwr, clkgen_on, clkgen_div}, 32'h0);
      step(5);
      check("R7 shadow later", {clkgen_lowpwr, clkgen_on, clkgen_div}, 32'h0);

      // R8 update-only command
      lc = n_launch;
      wr(A_CM, 32'h8020_0000);
      rd(A_CM, v); check("R8 start cycle1", v, 32'h8020_0000);
      step(3);
      rd(A_CM, v); check("R8 start last cycle", v[31], 1'b1);
      check("R8 shadow not yet", 32'(clkgen_div), 32'h0);
      step(1);
      rd(A_CM, v); check("R8 start cleared", v, 32'h0020_0000);
      check("R8 shadow loaded", {clkgen_lowpwr, clkgen_on, clkgen_div}, 32'h0003_0042);
      check("R8 no launch", n_launch, lc);

      // R4 lane select
      wr(A_LN, 32'h1); rd(A_LN, v); check("R4 four lanes", v, 32'h1);
      wr(A_LN, 32'h2); rd(A_LN, v); check("R4 eight lanes", v, 32'h2);
      wr(A_LN, 32'h3); rd(A_LN, v); check("R4 code 3 ignored", v, 32'h2);
      check("R4 lane output", lane_sel, 2'd2);
      wr(A_LN, 32'h0); rd(A_LN, v); check("R4 one lane", v, 32'h0);

      // R9 normal launch
      wr(A_AR, 32'h1234_5678);
      lc = n_launch;
      wr(A_CM, 32'h8000_0351);
      check("R9 launch high", eng_launch, 1'b1);
      check("R9 cmd word", eng_cmd, 32'h8000_0351);
      check("R9 arg word", eng_arg, 32'h1234_5678);
      step(1);
      check("R9 launch single", eng_launch, 1'b0);
      step(2);
      rd(A_CM, v); check("R9 start held", v, 32'h8000_0351);
      pulse_done();
      rd(A_CM, v); check("R9 start cleared", v, 32'h0000_0351);
      check("R9 one pulse", n_launch, lc + 1);

      // R10 write while pending
      lc = n_launch;
      wr(A_CM, 32'h8000_0005);
      wr(A_CM, 32'h8000_0777);
      rd(A_CM, v); check("R10 cmd kept", v, 32'h8000_0005);
      check("R10 engine word", eng_cmd, 32'h8000_0005);
      pulse_done();
      rd(A_CM, v); check("R10 after done", v, 32'h0000_0005);
      check("R10 single launch", n_launch, lc + 1);

      // R12 store without start
      lc = n_launch;
      wr(A_CM, 32'h0000_0A03);
      step(2);
      rd(A_CM, v); check("R12 stored", v, 32'h0000_0A03);
      check("R12 no launch", n_launch, lc);

      // R11 wait for previous transfer, normal command
      xfer_busy = 1'b1;
      wr(A_CM, 32'h8000_2002);
      check("R11 held cycle1", eng_launch, 1'b0);
      step(3);
      check("R11 held later", eng_launch, 1'b0);
      rd(A_CM, v); check("R11 start pending", v[31], 1'b1);
      xfer_busy = 1'b0; #1;
      check("R11 released", eng_launch, 1'b1);
      step(1);
      pulse_done();

      // R11 wait on a clock update
      wr(A_CK, 32'h0000_0010);
      xfer_busy = 1'b1;
      wr(A_CM, 32'h8020_2000);
      step(6);
      rd(A_CM, v); check("R11 upd held", v[31], 1'b1);
      check("R11 upd shadow old", 32'(clkgen_div), 32'h42);
      xfer_busy = 1'b0;
      step(3);
      rd(A_CM, v); check("R11 upd counting", v[31], 1'b1);
      step(1);
      rd(A_CM, v); check("R11 upd done", v[31], 1'b0);
      check("R11 upd shadow new", {clkgen_lowpwr, clkgen_on, clkgen_div}, 32'h10);

      // R6 flush bits
      wr(A_GC, 32'h0000_0012);
      rd(A_GC, v); check("R6 fifo bit", v, 32'h12);
      check("R6 fifo out", {dma_flush, fifo_flush}, 2'b01);
      step(3);
      rd(A_GC, v); check("R6 fifo last", v, 32'h12);
      step(1);
      rd(A_GC, v); check("R6 fifo clear", v, 32'h10);
      check("R6 fifo out low", fifo_flush, 1'b0);
      wr(A_GC, 32'h0000_0004);
      rd(A_GC, v); check("R6 dma bit", v, 32'h4);
      check("R6 dma out", dma_flush, 1'b1);
      step(4);
      rd(A_GC, v); check("R6 dma clear", v, 32'h0);

      // R5 / R13 soft reset
      wr(A_GC, 32'h8000_0020);
      wr(A_AR, 32'h0000_AAAA);
      wr(A_BS, 32'h0000_0040);
      wr(A_LN, 32'h1);
      wr(A_CK, 32'h0001_FFFF);
      wr(A_CM, 32'h8000_0009);
      wr(A_GC, 32'h0000_0001);
      rd(A_GC, v); check("R5 gctrl keeps bit31", v, 32'h8000_0001);
      rd(A_AR, v); check("R5 arg reset", v, 32'h0);
      rd(A_BS, v); check("R5 blksz reset", v, 32'h200);
      rd(A_LN, v); check("R5 lanes reset", v, 32'h0);
      rd(A_CK, v); check("R5 clock reset", v, 32'h0);
      check("R5 shadow reset", 32'(clkgen_div), 32'h0);
      rd(A_CM, v); check("R13 command aborted", v, 32'h0);
      wr(A_AR, 32'h0000_DEAD);
      rd(A_AR, v); check("R5 write ignored", v, 32'h0);
      step(5);
      rd(A_GC, v); check("R5 bit0 last", v, 32'h8000_0001);
      step(1);
      rd(A_GC, v); check("R5 bit0 clear", v, 32'h8000_0000);
      wr(A_AR, 32'h0000_0055);
      rd(A_AR, v); check("R5 writes resume", v, 32'h55);

      // R2 / R4 / R7 random register traffic
      m_lane = 2'd0; m_sh = 16'h0;
      for (int i = 0; i < 48; i++) begin
         logic [3:0]  a;
         logic [31:0] d;
         case ($urandom_range(0, 4))
            0: a = A_CK;
            1: a = A_LN;
            2: a = A_BS;
            3: a = A_BC;
            default: a = A_AR;
         endcase
         d = $urandom;
         wr(a, d);
         rd(a, v);
         if (a == A_LN) begin
            m_lane = exp_lane(m_lane, d);
            check("R4 random lanes", v, 32'(m_lane));
         end else begin
            check("R2 random readback", v, exp_read(a, d));
         end
         check("R7 random shadow", 32'(clkgen_div), 32'(m_sh));
      end

      // R9 random commands with random engine delay
      for (int i = 0; i < 12; i++) begin
         logic [31:0] w, ar;
         ar = $urandom;
         w  = 32'h8000_0000 | ($urandom & 32'h0000_97FF);
         wr(A_AR, ar);
         wr(A_CM, w);
         check("R9 random launch", eng_launch, 1'b1);
         check("R9 random cmd", eng_cmd, w);
         check("R9 random arg", eng_arg, ar);
         step(1 + $urandom_range(0, 5));
         rd(A_CM, v); check("R9 random pending", v, w);
         pulse_done();
         rd(A_CM, v); check("R9 random cleared", v, w & 32'h7FFF_FFFF);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule